// File: doc/BRIEF.md
# Three-Channel Compare Timer

This peripheral holds three independent 32-bit timers behind a single-cycle register bus. Each timer has a counter that software can write at any time, a reload value, and two compare registers. One shared control register turns each timer on, picks its count source (every bus clock or only clock cycles qualified by an external tick-enable), gates its overflow interrupt, and sets its direction.

When a timer runs past its limit it takes its reload value and raises an overflow event. The limit is all-ones when counting up and zero when counting down. A period of P ticks comes from reloading with 0xFFFFFFFF − (P − 1). Each compare register raises its own event when the advancing counter lands on its value, so one-shot timeouts can be armed at "current count plus delta". Nine event flags, three per timer, are held in a shared status register. A shared mask register selects which flags drive the per-timer interrupt lines. With every interrupt masked, a running timer serves as a free-running time base that software reads directly.

Top module: `tri_match_timer`

## Requirements
- R1: After reset every register reads 0 and all three interrupt outputs are low.
- R2: Word registers are addressed by byte address. Timer n (0..2) has counter at 16n+0x0, reload at 16n+0x4, compare A at 16n+0x8 and compare B at 16n+0xC. Control is at 0x30, status at 0x34 and mask at 0x38. Written values read back. Reads of unmapped addresses return 0. An access whose two low address bits are not 00 is ignored, and a read of that kind returns 0.
- R3: Control bit 3n enables timer n. With clock select clear, an enabled timer moves by one on every clock. Clearing the enable freezes the count, and the count value is kept.
- R4: Control bit 3n+1 set makes timer n move only on clock cycles where tick_en_i is high.
- R5: Counting up (control bit 9+n clear), an advance from 0xFFFFFFFF loads the reload value and sets status bit 3n+2.
- R6: Counting down (control bit 9+n set), the counter decrements. An advance from 0 loads the reload value and sets status bit 3n+2.
- R7: When an advance gives the counter a value equal to compare A, status bit 3n is set. When it equals compare B, status bit 3n+1 is set. Both become visible in the same cycle as the new count.
- R8: Status bits latch whatever the mask is. Writing 0 to a status bit clears it and writing 1 leaves it as it was. An event in the same cycle as a clearing write leaves the bit set.
- R9: irq_o[n] is the OR of status bits 3n, 3n+1 and 3n+2, each ANDed with the same mask bit (1 = pass). Bit 3n+2 is passed only while control bit 3n+2 (overflow interrupt enable) is set.
- R10: A counter write sets the count on the next cycle, overrides that cycle's advance and raises no event, even when the written value equals a compare register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and count clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_sel_i | input | 1 | Access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| tick_en_i | input | 1 | External count qualifier for timers with clock select set |
| irq_o | output | 3 | One interrupt line per timer |

## Verification
The bench runs a timer across the all-ones wrap and checks both the reload value and the spacing of overflows. A design that wrapped to zero, or that stalled for one cycle at the limit, would show the wrong count or an extra tick in the period. The down-count test drives the counter through zero while both compare registers hold zero. This catches a design that raises the overflow one step early, or that misses the compare hit on the zero count. It also writes a counter value equal to a compare register. This catches a design that treats a write as an advance and sets a compare flag. It then times a status-clearing write into the exact cycle of a compare hit, and a design that lets the clear win would lose that event. The overflow flag is read back with its interrupt gate open and with it shut. This exposes a design that gates the latch rather than the output.

// File: rtl/tmt_pkg.sv
package tmt_pkg;
    localparam int TMR_N  = 3;
    localparam int DATA_W = 32;
    localparam int EV_PER = 3;
    localparam int EV_W   = TMR_N * EV_PER;
    localparam int CTRL_W = TMR_N * 4;
    localparam int ADDR_W = 6;
    localparam int WORD_W = ADDR_W - 2;
    localparam int GRP_W  = WORD_W - 2;

    localparam int EV_CMPA = 0;
    localparam int EV_CMPB = 1;
    localparam int EV_WRAP = 2;

    localparam logic [WORD_W-1:0] WORD_CTRL = WORD_W'(12);
    localparam logic [WORD_W-1:0] WORD_STAT = WORD_W'(13);
    localparam logic [WORD_W-1:0] WORD_MASK = WORD_W'(14);

    typedef enum logic [1:0] {
        SLOT_CNT  = 2'd0,
        SLOT_RLD  = 2'd1,
        SLOT_CMPA = 2'd2,
        SLOT_CMPB = 2'd3
    } slot_e;

    typedef struct packed {
        logic down;
        logic wrap_ie;
        logic use_tick;
        logic run;
    } chan_cfg_t;
endpackage

// File: rtl/tmt_channel.sv
module tmt_channel
    import tmt_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  chan_cfg_t         cfg_i,
    input  logic              tick_en_i,
    input  logic              we_i,
    input  slot_e             slot_i,
    input  logic [W-1:0]      wdata_i,
    output logic [W-1:0]      count_o,
    output logic [W-1:0]      reload_o,
    output logic [W-1:0]      cmpa_o,
    output logic [W-1:0]      cmpb_o,
    output logic [EV_PER-1:0] ev_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] rld;
        logic [W-1:0] cmpa;
        logic [W-1:0] cmpb;
    } chan_st_t;

    chan_st_t            st_d, st_q;
    logic [EV_PER-1:0]   ev_d;
    logic                step_w;
    logic                at_lim_w;
    logic                cnt_wr_w;

    always_comb begin
        st_d     = st_q;
        ev_d     = '0;
        step_w   = cfg_i.run && (!cfg_i.use_tick || tick_en_i);
        at_lim_w = cfg_i.down ? (st_q.cnt == '0) : (st_q.cnt == '1);
        cnt_wr_w = we_i && (slot_i == SLOT_CNT);

        if (we_i) begin
            case (slot_i)
                SLOT_RLD:  st_d.rld  = wdata_i;
                SLOT_CMPA: st_d.cmpa = wdata_i;
                SLOT_CMPB: st_d.cmpb = wdata_i;
                default:   ;
            endcase
        end

        if (cnt_wr_w) begin
            st_d.cnt = wdata_i;
        end else if (step_w) begin
            if (at_lim_w) begin
                st_d.cnt      = st_q.rld;
                ev_d[EV_WRAP] = 1'b1;
            end else if (cfg_i.down) begin
                st_d.cnt = st_q.cnt - W'(1);
            end else begin
                st_d.cnt = st_q.cnt + W'(1);
            end
            ev_d[EV_CMPA] = (st_d.cnt == st_q.cmpa);
            ev_d[EV_CMPB] = (st_d.cnt == st_q.cmpb);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o  = st_q.cnt;
    assign reload_o = st_q.rld;
    assign cmpa_o   = st_q.cmpa;
    assign cmpb_o   = st_q.cmpb;
    assign ev_o     = ev_d;

    AST_FREEZE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cfg_i.run && !cnt_wr_w) |=> $stable(st_q.cnt)); // R3
    AST_LIMIT_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_w && at_lim_w && !cnt_wr_w) |=> (st_q.cnt == $past(st_q.rld))); // R5
    AST_CNT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_wr_w |=> (st_q.cnt == $past(wdata_i))); // R10
    AST_NO_EVENT_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_wr_w |-> (ev_o == '0)); // R10
endmodule

// File: rtl/tmt_irq.sv
module tmt_irq
    import tmt_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [EV_W-1:0]  ev_i,
    input  logic             st_we_i,
    input  logic             mk_we_i,
    input  logic [EV_W-1:0]  wdata_i,
    input  logic [TMR_N-1:0] wrap_ie_i,
    output logic [EV_W-1:0]  status_o,
    output logic [EV_W-1:0]  mask_o,
    output logic [TMR_N-1:0] irq_o
);
    typedef struct packed {
        logic [EV_W-1:0] status;
        logic [EV_W-1:0] mask;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.status = (st_we_i ? (st_q.status & wdata_i) : st_q.status) | ev_i;
        if (mk_we_i) begin
            st_d.mask = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar n = 0; n < TMR_N; n++) begin : g_line
        logic [EV_PER-1:0] gate_w;
        assign gate_w   = {wrap_ie_i[n], 2'b11};
        assign irq_o[n] = |(st_q.status[EV_PER*n +: EV_PER]
                          & st_q.mask[EV_PER*n +: EV_PER] & gate_w);
    end

    assign status_o = st_q.status;
    assign mask_o   = st_q.mask;

    AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_we_i |=> ((st_q.status & $past(st_q.status)) == $past(st_q.status))); // R8
    AST_EVENT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ev_i != '0) |=> ((st_q.status & $past(ev_i)) == $past(ev_i))); // R8
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.mask == '0) |-> (irq_o == '0)); // R9
endmodule

// File: rtl/tri_match_timer.sv
module tri_match_timer
    import tmt_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              tick_en_i,
    output logic [TMR_N-1:0]  irq_o
);
    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
    } top_st_t;

    top_st_t            st_d, st_q;
    logic               aligned_w, wr_hit_w, rd_hit_w;
    logic [WORD_W-1:0]  word_w;
    logic [GRP_W-1:0]   grp_w;
    slot_e              slot_w;
    logic               st_we_w, mk_we_w;

    chan_cfg_t          cfg_a   [TMR_N];
    logic [DATA_W-1:0]  cnt_a   [TMR_N];
    logic [DATA_W-1:0]  rld_a   [TMR_N];
    logic [DATA_W-1:0]  cmpa_a  [TMR_N];
    logic [DATA_W-1:0]  cmpb_a  [TMR_N];
    logic [EV_W-1:0]    ev_all;
    logic [TMR_N-1:0]   wrap_ie;
    logic [EV_W-1:0]    status_w, mask_w;

    assign aligned_w = (bus_addr_i[1:0] == 2'b00);
    assign word_w    = bus_addr_i[ADDR_W-1:2];
    assign grp_w     = word_w[WORD_W-1:2];
    assign slot_w    = slot_e'(word_w[1:0]);
    assign wr_hit_w  = bus_sel_i && bus_wr_i && aligned_w;
    assign rd_hit_w  = bus_sel_i && !bus_wr_i && aligned_w;
    assign st_we_w   = wr_hit_w && (word_w == WORD_STAT);
    assign mk_we_w   = wr_hit_w && (word_w == WORD_MASK);

    always_comb begin
        st_d = st_q;
        if (wr_hit_w && (word_w == WORD_CTRL)) begin
            st_d.ctrl = bus_wdata_i[CTRL_W-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar n = 0; n < TMR_N; n++) begin : g_chan
        logic [EV_PER-1:0] ev_w;

        assign cfg_a[n] = '{down:     st_q.ctrl[EV_PER*TMR_N + n],
                            wrap_ie:  st_q.ctrl[EV_PER*n + 2],
                            use_tick: st_q.ctrl[EV_PER*n + 1],
                            run:      st_q.ctrl[EV_PER*n]};
        assign wrap_ie[n] = cfg_a[n].wrap_ie;

        tmt_channel #(.W(DATA_W)) u_chan (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .cfg_i     (cfg_a[n]),
            .tick_en_i (tick_en_i),
            .we_i      (wr_hit_w && (grp_w == GRP_W'(n))),
            .slot_i    (slot_w),
            .wdata_i   (bus_wdata_i),
            .count_o   (cnt_a[n]),
            .reload_o  (rld_a[n]),
            .cmpa_o    (cmpa_a[n]),
            .cmpb_o    (cmpb_a[n]),
            .ev_o      (ev_w)
        );
        assign ev_all[EV_PER*n +: EV_PER] = ev_w;
    end

    tmt_irq u_irq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ev_i      (ev_all),
        .st_we_i   (st_we_w),
        .mk_we_i   (mk_we_w),
        .wdata_i   (bus_wdata_i[EV_W-1:0]),
        .wrap_ie_i (wrap_ie),
        .status_o  (status_w),
        .mask_o    (mask_w),
        .irq_o     (irq_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (rd_hit_w) begin
            for (int n = 0; n < TMR_N; n++) begin
                if (grp_w == GRP_W'(n)) begin
                    case (slot_w)
                        SLOT_CNT:  bus_rdata_o = cnt_a[n];
                        SLOT_RLD:  bus_rdata_o = rld_a[n];
                        SLOT_CMPA: bus_rdata_o = cmpa_a[n];
                        default:   bus_rdata_o = cmpb_a[n];
                    endcase
                end
            end
            case (word_w)
                WORD_CTRL: bus_rdata_o = DATA_W'(st_q.ctrl);
                WORD_STAT: bus_rdata_o = DATA_W'(status_w);
                WORD_MASK: bus_rdata_o = DATA_W'(mask_w);
                default:   ;
            endcase
        end
    end

    AST_IDLE_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_hit_w |-> (bus_rdata_o == '0)); // R2
endmodule

// File: tb/tri_match_timer_bench.sv
module tri_match_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick = 1'b0;
    logic [2:0]  irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    tri_match_timer u_tri_match_timer (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_sel_i   (sel),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .tick_en_i   (tick),
        .irq_o       (irq)
    );

    // monitor: compares the outputs of the current cycle against the queue head
    always @(negedge clk) begin : mon
        item_t       it;
        logic [31:0] act;
        if (sb_q.size() != 0) begin
            it  = sb_q.pop_front();
            act = it.is_irq ? {29'b0, irq} : rdata;
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        sel = 1'b1; wr = 1'b0; addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic irq_chk(input logic [2:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        sel = 1'b0; wr = 1'b0;
        it.is_irq = 1'b1; it.exp = {29'b0, e}; it.tag = tag;
        sb_q.push_back(it);
    endtask

    localparam logic [5:0] A_CTRL = 6'h30;
    localparam logic [5:0] A_STAT = 6'h34;
    localparam logic [5:0] A_MASK = 6'h38;

    function automatic logic [5:0] a_of(input int t, input int s);
        return 6'(16 * t + 4 * s);
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : drv
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd_chk(a_of(0, 0), 32'h0, "R1 count0");
        rd_chk(a_of(2, 1), 32'h0, "R1 reload2");
        rd_chk(A_CTRL, 32'h0, "R1 ctrl");
        rd_chk(A_STAT, 32'h0, "R1 status");
        rd_chk(A_MASK, 32'h0, "R1 mask");
        irq_chk(3'b000, "R1 irq");

        // R2 map and readback
        wr_reg(a_of(1, 1), 32'hDEADBEEF);
        rd_chk(a_of(1, 1), 32'hDEADBEEF, "R2 reload1");
        rd_chk(6'h15, 32'h0, "R2 unaligned read");
        wr_reg(6'h16, 32'h0);
        rd_chk(a_of(1, 1), 32'hDEADBEEF, "R2 unaligned write ignored");
        wr_reg(a_of(2, 3), 32'h12345678);
        rd_chk(a_of(2, 3), 32'h12345678, "R2 cmpb2");
        wr_reg(A_MASK, 32'h1FF);
        rd_chk(A_MASK, 32'h1FF, "R2 mask");
        wr_reg(A_MASK, 32'h0);
        rd_chk(6'h3C, 32'h0, "R2 unmapped");

        // R3 run and freeze
        wr_reg(a_of(0, 0), 32'd100);
        wr_reg(A_CTRL, 32'h001);
        cyc(); cyc(); cyc();
        wr_reg(A_CTRL, 32'h000);
        rd_chk(a_of(0, 0), 32'd104, "R3 counted");
        cyc(); cyc(); cyc(); cyc();
        rd_chk(a_of(0, 0), 32'd104, "R3 frozen");
        rd_chk(A_CTRL, 32'h0, "R2 ctrl readback");

        // R10 counter write while running
        wr_reg(A_CTRL, 32'h001);
        cyc();
        wr_reg(a_of(0, 0), 32'd500);
        rd_chk(a_of(0, 0), 32'd500, "R10 write overrides");
        rd_chk(a_of(0, 0), 32'd501, "R10 resumes");
        wr_reg(A_CTRL, 32'h000);

        // R4 tick qualifier on timer 1
        wr_reg(A_CTRL, 32'h018);
        cyc(); cyc(); cyc();
        rd_chk(a_of(1, 0), 32'd0, "R4 no tick no move");
        tick = 1'b1;
        cyc(); cyc(); cyc(); cyc();
        tick = 1'b0;
        rd_chk(a_of(1, 0), 32'd4, "R4 four ticks");
        wr_reg(A_CTRL, 32'h000);

        // R5 up wrap with period 3 on timer 2
        wr_reg(a_of(2, 1), 32'hFFFFFFFD);
        wr_reg(a_of(2, 0), 32'hFFFFFFFE);
        wr_reg(A_CTRL, 32'h040);
        cyc(); cyc();
        rd_chk(a_of(2, 0), 32'hFFFFFFFD, "R5 reload after wrap");
        rd_chk(A_STAT, 32'h100, "R5 wrap flag");
        wr_reg(A_CTRL, 32'h000);
        rd_chk(a_of(2, 0), 32'hFFFFFFFD, "R5 second wrap after 3");

        // R9 masking and wrap gate, R8 sticky
        irq_chk(3'b000, "R9 masked off");
        wr_reg(A_MASK, 32'h100);
        irq_chk(3'b000, "R9 wrap gate closed");
        wr_reg(A_CTRL, 32'h100);
        irq_chk(3'b100, "R9 wrap gate open");
        wr_reg(A_CTRL, 32'h000);
        wr_reg(A_MASK, 32'h000);
        wr_reg(A_STAT, 32'h1FF);
        rd_chk(A_STAT, 32'h100, "R8 write one keeps");
        wr_reg(A_STAT, 32'h0FF);
        rd_chk(A_STAT, 32'h000, "R8 write zero clears");

        // R6 down count through zero on timer 0 (compare regs are 0)
        wr_reg(a_of(0, 1), 32'd10);
        wr_reg(a_of(0, 0), 32'd2);
        wr_reg(A_CTRL, 32'h201);
        cyc(); cyc(); cyc();
        rd_chk(A_STAT, 32'h007, "R6 underflow and R7 zero hits");
        rd_chk(a_of(0, 0), 32'd9, "R6 reloaded then decremented");
        wr_reg(A_CTRL, 32'h000);
        wr_reg(A_STAT, 32'h000);
        rd_chk(A_STAT, 32'h000, "R8 cleared");

        // R7 compare hits on timer 1
        wr_reg(a_of(1, 2), 32'd20);
        wr_reg(a_of(1, 3), 32'd22);
        wr_reg(a_of(1, 0), 32'd18);
        wr_reg(A_CTRL, 32'h008);
        cyc(); cyc();
        rd_chk(A_STAT, 32'h008, "R7 compare A");
        cyc();
        rd_chk(A_STAT, 32'h018, "R7 compare B");
        wr_reg(A_CTRL, 32'h000);
        irq_chk(3'b000, "R9 masked compare");
        wr_reg(A_MASK, 32'h010);
        irq_chk(3'b010, "R9 compare B passes");
        wr_reg(A_MASK, 32'h000);
        wr_reg(A_STAT, 32'h000);

        // R10 write equal to compare raises nothing
        wr_reg(a_of(1, 0), 32'd20);
        cyc();
        rd_chk(A_STAT, 32'h000, "R10 no event on write");
        rd_chk(a_of(1, 0), 32'd20, "R10 value written");

        // R8 event beats clear in the same cycle
        wr_reg(a_of(0, 2), 32'd50);
        wr_reg(a_of(0, 0), 32'd49);
        wr_reg(A_CTRL, 32'h001);
        wr_reg(A_STAT, 32'h000);
        rd_chk(A_STAT, 32'h001, "R8 event wins over clear");
        wr_reg(A_CTRL, 32'h000);
        cyc(); cyc();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule